// File: doc/BRIEF.md
# Upset-Tolerant FSM State Register

This block is the state register of a small control state machine (two to eight states) that must stay safe when a single stored bit is upset. The surrounding control logic gives it a logical next-state index on every clock. The block turns that index into a base code (one-hot, plain binary, Johnson or Gray, chosen at compile time) and adds redundancy bits before it stores the word. On the read side it returns a decoded current-state index that is always a legal state, together with an error pulse.

One compile-time parameter selects the recovery policy. In correcting mode the stored words are at least three bit flips apart, so the decoder repairs any single flip in place and the machine continues along its normal path. The other three modes store words at least two flips apart. They detect a single flip and send the machine to one of three states: the synchronous-reset state, the state the register holds at power-up, or a separately named default state that the normal transitions may never reach. For testing, a fault-injection mask is XORed into the word as it is written.

Top module: `ftsr_state_reg`

## Requirements
- R1: When `rst` is high at a rising edge, the register loads the RESET_STATE codeword and ignores `fault_mask`. In the next cycle `cur_idx` equals RESET_STATE and `err_pulse` is low.
- R2: Before any reset, the register holds the codeword of POWERON_STATE, and `cur_idx` shows that state.
- R3: When the stored word is a legal codeword, `cur_idx` shows its state and `err_pulse` and `corrected` are low. Each edge without reset stores the codeword of `next_idx`, which appears on `cur_idx` one cycle later.
- R4: A `next_idx` value of N_STATES or more stores the RESET_STATE codeword.
- R5: At each edge without reset, bit i of `fault_mask` inverts bit i of the word written. The word is the base code in the low bits with the check bits above it. The base is N_STATES bits for one-hot, ceil(N_STATES/2) bits for Johnson, and ceil(log2 N_STATES) bits for binary and Gray. Correcting mode adds the smallest r with 2^r >= base+r+1 check bits. The other modes add one even-parity bit.
- R6: In correcting mode, a stored word one flip away from a codeword raises `err_pulse` and `corrected` for that cycle and shows the intended state on `cur_idx`. The next edge stores `next_idx` as usual.
- R7: In reset-recovery mode, a word that is not a codeword raises `err_pulse` with `corrected` low and shows RESET_STATE. The next edge stores the RESET_STATE codeword and ignores `next_idx`.
- R8: In power-on-recovery mode, the same detection instead shows and stores POWERON_STATE.
- R9: In default-recovery mode, the same detection shows and stores DEFAULT_STATE, even when the normal transitions never enter that state.
- R10: With every base encoding, distinct state codewords differ in at least three bits in correcting mode and in at least two bits in the other modes. Every single-bit flip of a stored state is therefore caught.
- R11: Without further injection, `err_pulse` lasts exactly one cycle and the next cycle shows a clean state.
- R12: `cur_idx` is below N_STATES in every cycle, including cycles with a corrupted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| next_idx | input | IW | Logical next-state index from the transition logic |
| fault_mask | input | W | Test mask XORed into the word being written |
| cur_idx | output | IW | Decoded current-state index |
| err_pulse | output | 1 | Stored word is not a legal codeword |
| corrected | output | 1 | Correcting mode repaired a single flipped bit |

## Verification
Five instances cover all four base encodings and all four policies. Each is driven by a counting machine, and the default-policy machine skips its last state so that this state is reached only through recovery. The tests apply a clean run, a single flip on each codeword bit followed by clean cycles, flips on two consecutive cycles, an out-of-range next index, and a reset asserted while a mask is present. The single-bit sweep separates correction from detection and shows which recovery target each policy picks. The double-cycle flips show whether the machine keeps recovering when it is upset again at once. The reset-with-mask case shows that reset has priority over injection.

// File: rtl/ftsr_pkg.sv
package ftsr_pkg;

    localparam int MAXW = 16;
    localparam int MAXN = 8;
    localparam int IDXW = $clog2(MAXN);

    typedef enum logic [1:0] {
        ENC_ONEHOT,
        ENC_BINARY,
        ENC_JOHNSON,
        ENC_GRAY
    } base_enc_e;

    typedef enum logic [1:0] {
        REC_CORRECT,
        REC_TO_RESET,
        REC_TO_POWERON,
        REC_TO_DEFAULT
    } recov_e;

    typedef logic [MAXW-1:0] word_t;

    // Result of comparing the stored word against every state codeword
    typedef struct packed {
        logic            valid;
        logic            near;
        logic [IDXW-1:0] exact_idx;
        logic [IDXW-1:0] near_idx;
    } match_t;

    // Decision for the current cycle
    typedef struct packed {
        logic [IDXW-1:0] cur;
        logic [IDXW-1:0] load;
        logic            err;
        logic            corr;
    } step_t;

    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int base_width(int n, base_enc_e e);
        int k;
        case (e)
            ENC_ONEHOT:  k = n;
            ENC_JOHNSON: k = (n + 1) / 2;
            default:     k = idx_width(n);
        endcase
        return k;
    endfunction

    function automatic int check_width(int k, recov_e p);
        int r;
        r = 1;
        if (p == REC_CORRECT) begin
            r = 2;
            while ((1 << r) < k + r + 1) r++;
        end
        return r;
    endfunction

    function automatic int cw_width(int n, base_enc_e e, recov_e p);
        return base_width(n, e) + check_width(base_width(n, e), p);
    endfunction

    // Parity-matrix column of data bit i: i-th value >= 3 that is not a power of two
    function automatic int hcol(int i);
        int c;
        int r;
        c = 0;
        r = 0;
        for (int v = 3; v < 64; v++) begin
            if (((v & (v - 1)) != 0) && (r == 0)) begin
                if (c == i) r = v;
                c++;
            end
        end
        return r;
    endfunction

    function automatic word_t base_code(int s, int n, base_enc_e e);
        word_t b;
        int    k;
        b = '0;
        k = base_width(n, e);
        case (e)
            ENC_ONEHOT: b[s] = 1'b1;
            ENC_BINARY: b = word_t'(s);
            ENC_GRAY:   b = word_t'(s ^ (s >> 1));
            default: begin
                if (s < k) b = word_t'((1 << s) - 1);
                else       b = word_t'(((1 << k) - 1) & ~((1 << (s - k)) - 1));
            end
        endcase
        return b;
    endfunction

    function automatic word_t codeword(int s, int n, base_enc_e e, recov_e p);
        word_t b;
        word_t chk;
        int    k;
        b   = base_code(s, n, e);
        k   = base_width(n, e);
        chk = '0;
        if (p == REC_CORRECT) begin
            for (int i = 0; i < MAXW; i++) begin
                if (i < k && b[i]) chk = chk ^ word_t'(hcol(i));
            end
        end else begin
            chk[0] = ^b;
        end
        return b | (chk << k);
    endfunction

endpackage

// File: rtl/ftsr_encode.sv
module ftsr_encode
    import ftsr_pkg::*;
#(
    parameter int        N     = 6,
    parameter base_enc_e ENC   = ENC_GRAY,
    parameter recov_e    POL   = REC_CORRECT,
    parameter int        RST_S = 0,
    parameter int        W     = 6
) (
    input  logic [IDXW-1:0] idx,
    output logic [W-1:0]    word
);

    logic [W-1:0] tbl [N];

    for (genvar s = 0; s < N; s++) begin : g_tbl
        localparam word_t FULL = codeword(s, N, ENC, POL);
        assign tbl[s] = FULL[W-1:0];
    end

    // Out-of-range index falls back to the reset codeword
    always_comb begin
        word = tbl[RST_S];
        for (int s = 0; s < N; s++) begin
            if (idx == IDXW'(s)) word = tbl[s];
        end
    end

endmodule

// File: rtl/ftsr_match.sv
module ftsr_match
    import ftsr_pkg::*;
#(
    parameter int        N   = 6,
    parameter base_enc_e ENC = ENC_GRAY,
    parameter recov_e    POL = REC_CORRECT,
    parameter int        W   = 6
) (
    input  logic [W-1:0] word,
    output match_t       m
);

    logic [N-1:0] hit;
    logic [N-1:0] near;

    for (genvar s = 0; s < N; s++) begin : g_cmp
        localparam word_t FULL = codeword(s, N, ENC, POL);
        assign hit[s]  = (word == FULL[W-1:0]);
        assign near[s] = ($countones(word ^ FULL[W-1:0]) == 1);
    end

    always_comb begin
        m = '0;
        for (int s = 0; s < N; s++) begin
            if (hit[s]) begin
                m.valid     = 1'b1;
                m.exact_idx = IDXW'(s);
            end
            if (near[s]) begin
                m.near     = 1'b1;
                m.near_idx = IDXW'(s);
            end
        end
    end

endmodule

// File: rtl/ftsr_recover.sv
module ftsr_recover
    import ftsr_pkg::*;
#(
    parameter recov_e POL   = REC_CORRECT,
    parameter int     RST_S = 0,
    parameter int     PWR_S = 0,
    parameter int     DEF_S = 0
) (
    input  match_t          m,
    input  logic [IDXW-1:0] next_idx,
    output step_t           st
);

    localparam int TGT = (POL == REC_TO_POWERON) ? PWR_S :
                         (POL == REC_TO_DEFAULT) ? DEF_S : RST_S;

    always_comb begin
        st.err  = !m.valid;
        st.corr = 1'b0;
        if (m.valid) begin
            st.cur  = m.exact_idx;
            st.load = next_idx;
        end else if (POL == REC_CORRECT && m.near) begin
            st.cur  = m.near_idx;
            st.load = next_idx;
            st.corr = 1'b1;
        end else begin
            st.cur  = IDXW'(TGT);
            st.load = IDXW'(TGT);
        end
    end

endmodule

// File: rtl/ftsr_state_reg.sv
module ftsr_state_reg
    import ftsr_pkg::*;
#(
    parameter int        N_STATES      = 6,
    parameter base_enc_e BASE_ENC      = ENC_GRAY,
    parameter recov_e    RECOVERY      = REC_CORRECT,
    parameter int        RESET_STATE   = 0,
    parameter int        POWERON_STATE = 0,
    parameter int        DEFAULT_STATE = 0,
    localparam int       IW            = idx_width(N_STATES),
    localparam int       W             = cw_width(N_STATES, BASE_ENC, RECOVERY)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] next_idx,
    input  logic [W-1:0]  fault_mask,
    output logic [IW-1:0] cur_idx,
    output logic          err_pulse,
    output logic          corrected
);

    localparam word_t        RST_FULL = codeword(RESET_STATE, N_STATES, BASE_ENC, RECOVERY);
    localparam word_t        PWR_FULL = codeword(POWERON_STATE, N_STATES, BASE_ENC, RECOVERY);
    localparam logic [W-1:0] RST_WORD = RST_FULL[W-1:0];
    localparam logic [W-1:0] PWR_WORD = PWR_FULL[W-1:0];

    logic [W-1:0]    word_q = PWR_WORD;
    logic [W-1:0]    word_d;
    logic [IDXW-1:0] nxt_w;
    match_t          m;
    step_t           st;

    assign nxt_w = IDXW'(next_idx);

    ftsr_match #(
        .N   (N_STATES),
        .ENC (BASE_ENC),
        .POL (RECOVERY),
        .W   (W)
    ) u_match (
        .word (word_q),
        .m    (m)
    );

    ftsr_recover #(
        .POL   (RECOVERY),
        .RST_S (RESET_STATE),
        .PWR_S (POWERON_STATE),
        .DEF_S (DEFAULT_STATE)
    ) u_recover (
        .m        (m),
        .next_idx (nxt_w),
        .st       (st)
    );

    ftsr_encode #(
        .N     (N_STATES),
        .ENC   (BASE_ENC),
        .POL   (RECOVERY),
        .RST_S (RESET_STATE),
        .W     (W)
    ) u_encode (
        .idx  (st.load),
        .word (word_d)
    );

    always_ff @(posedge clk) begin
        if (rst) word_q <= RST_WORD;
        else     word_q <= word_d ^ fault_mask;
    end

    assign cur_idx   = IW'(st.cur);
    assign err_pulse = st.err;
    assign corrected = st.corr;

endmodule

// File: rtl/ftsr_state_reg_chk.sv
module ftsr_state_reg_chk
    import ftsr_pkg::*;
#(
    parameter int     N_STATES      = 6,
    parameter recov_e RECOVERY      = REC_CORRECT,
    parameter int     RESET_STATE   = 0,
    parameter int     POWERON_STATE = 0,
    parameter int     DEFAULT_STATE = 0,
    parameter int     IW            = 3,
    parameter int     W             = 6
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  fault_mask,
    input logic [IW-1:0] cur_idx,
    input logic          err_pulse,
    input logic          corrected
);

    localparam int TGT = (RECOVERY == REC_TO_POWERON) ? POWERON_STATE :
                         (RECOVERY == REC_TO_DEFAULT) ? DEFAULT_STATE : RESET_STATE;

    // R1
    reset_load_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_idx == IW'(RESET_STATE) && !err_pulse));

    // R12
    state_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cur_idx) < N_STATES);

    // R6
    corr_needs_err_chk: assert property (@(posedge clk) disable iff (rst)
        corrected |-> err_pulse);

    // R11
    clean_after_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fault_mask) == '0) |-> !err_pulse);

    if (RECOVERY == REC_CORRECT) begin : g_corr
        // R6
        single_flip_fixed_chk: assert property (@(posedge clk) disable iff (rst)
            (!err_pulse && $countones(fault_mask) == 1) |=> (err_pulse && corrected));
    end else begin : g_det
        // R10
        single_flip_seen_chk: assert property (@(posedge clk) disable iff (rst)
            (!err_pulse && $countones(fault_mask) == 1) |=> (err_pulse && !corrected));
        // R7
        recover_target_chk: assert property (@(posedge clk) disable iff (rst)
            (err_pulse && fault_mask == '0) |=> (cur_idx == IW'(TGT) && !err_pulse));
    end

endmodule

bind ftsr_state_reg ftsr_state_reg_chk #(
    .N_STATES      (N_STATES),
    .RECOVERY      (RECOVERY),
    .RESET_STATE   (RESET_STATE),
    .POWERON_STATE (POWERON_STATE),
    .DEFAULT_STATE (DEFAULT_STATE),
    .IW            (IW),
    .W             (W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fault_mask (fault_mask),
    .cur_idx    (cur_idx),
    .err_pulse  (err_pulse),
    .corrected  (corrected)
);

// File: tb/ftsr_state_reg_test.sv
module ftsr_state_reg_test;
    import ftsr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 5;
    // per instance: state count, policy (0 correct 1 reset 2 power-on 3 default)
    localparam int NN [NI] = '{6, 5, 8, 7, 8};
    localparam int PO [NI] = '{0, 1, 2, 3, 0};
    localparam int RS [NI] = '{0, 2, 0, 1, 5};
    localparam int PW [NI] = '{0, 0, 3, 0, 0};
    localparam int DF [NI] = '{0, 0, 0, 6, 0};
    localparam int MD [NI] = '{6, 5, 8, 6, 8};   // counter modulus of the example FSM
    // R5 codeword widths: gray6 3+3, onehot5 5+1, johnson8 4+1, binary7 3+1, onehot8 8+4
    localparam int WW [NI] = '{6, 6, 5, 4, 12};

    logic             clk;
    logic             rst;
    logic [2:0]       nxt [NI];
    logic [15:0]      msk [NI];
    wire  [3*NI-1:0]  cur_v;
    wire  [NI-1:0]    err_v;
    wire  [NI-1:0]    cor_v;

    int    L   [NI];
    int    fl  [NI];
    string why [NI];
    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 0;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    ftsr_state_reg #(.N_STATES(6), .BASE_ENC(ENC_GRAY), .RECOVERY(REC_CORRECT),
        .RESET_STATE(0), .POWERON_STATE(0), .DEFAULT_STATE(0)) uut (
        .clk(clk), .rst(rst), .next_idx(nxt[0]), .fault_mask(msk[0][WW[0]-1:0]),
        .cur_idx(cur_v[2:0]), .err_pulse(err_v[0]), .corrected(cor_v[0]));

    ftsr_state_reg #(.N_STATES(5), .BASE_ENC(ENC_ONEHOT), .RECOVERY(REC_TO_RESET),
        .RESET_STATE(2), .POWERON_STATE(0), .DEFAULT_STATE(0)) u_rst (
        .clk(clk), .rst(rst), .next_idx(nxt[1]), .fault_mask(msk[1][WW[1]-1:0]),
        .cur_idx(cur_v[5:3]), .err_pulse(err_v[1]), .corrected(cor_v[1]));

    ftsr_state_reg #(.N_STATES(8), .BASE_ENC(ENC_JOHNSON), .RECOVERY(REC_TO_POWERON),
        .RESET_STATE(0), .POWERON_STATE(3), .DEFAULT_STATE(0)) u_pwr (
        .clk(clk), .rst(rst), .next_idx(nxt[2]), .fault_mask(msk[2][WW[2]-1:0]),
        .cur_idx(cur_v[8:6]), .err_pulse(err_v[2]), .corrected(cor_v[2]));

    ftsr_state_reg #(.N_STATES(7), .BASE_ENC(ENC_BINARY), .RECOVERY(REC_TO_DEFAULT),
        .RESET_STATE(1), .POWERON_STATE(0), .DEFAULT_STATE(6)) u_def (
        .clk(clk), .rst(rst), .next_idx(nxt[3]), .fault_mask(msk[3][WW[3]-1:0]),
        .cur_idx(cur_v[11:9]), .err_pulse(err_v[3]), .corrected(cor_v[3]));

    ftsr_state_reg #(.N_STATES(8), .BASE_ENC(ENC_ONEHOT), .RECOVERY(REC_CORRECT),
        .RESET_STATE(5), .POWERON_STATE(0), .DEFAULT_STATE(0)) u_cor8 (
        .clk(clk), .rst(rst), .next_idx(nxt[4]), .fault_mask(msk[4][WW[4]-1:0]),
        .cur_idx(cur_v[14:12]), .err_pulse(err_v[4]), .corrected(cor_v[4]));

    function automatic int tgt(int i);
        return (PO[i] == 2) ? PW[i] : (PO[i] == 3) ? DF[i] : RS[i];
    endfunction

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < NI; i++) begin
            int    ec;
            int    ee;
            int    eo;
            int    ac;
            string tag;
            ac = int'(cur_v[3*i +: 3]);
            if (fl[i] == 0) begin
                ec = L[i]; ee = 0; eo = 0; tag = why[i];
            end else if (PO[i] == 0) begin
                ec = L[i]; ee = 1; eo = 1; tag = "R6 R5 R10";
            end else begin
                ec = tgt(i); ee = 1; eo = 0;
                tag = (PO[i] == 1) ? "R7 R5 R10" : (PO[i] == 2) ? "R8 R5 R10" : "R9 R5 R10";
            end
            vectors++;
            if (ac != ec || int'(err_v[i]) != ee || int'(cor_v[i]) != eo) begin
                miscompares++;
                $display("FAIL %s inst %0d: cur=%0d err=%0b cor=%0b expected cur=%0d err=%0d cor=%0d",
                         tag, i, ac, err_v[i], cor_v[i], ec, ee, eo);
            end
            vectors++;
            if (ac >= NN[i]) begin
                miscompares++;
                $display("FAIL R12 inst %0d: cur=%0d expected below %0d", i, ac, NN[i]);
            end
        end
    endtask

    // compare, then drive the next edge's inputs and advance the model
    task automatic step(input bit do_rst, input int bsel, input bit oor);
        check_all();
        rst = do_rst;
        for (int i = 0; i < NI; i++) begin
            int ecur;
            int nx;
            bit bad;
            bad  = (fl[i] != 0) && (PO[i] != 0);
            ecur = bad ? tgt(i) : L[i];
            nx   = (oor && i == 0) ? 7 : (ecur + 1) % MD[i];
            nxt[i] = 3'(nx);
            msk[i] = (bsel >= 0 && bsel < WW[i]) ? (16'd1 << bsel) : 16'd0;
            if (do_rst) begin
                L[i] = RS[i]; fl[i] = 0; why[i] = "R1";
            end else begin
                if (bad) begin
                    L[i] = tgt(i); why[i] = "R11";
                end else if (nx < NN[i]) begin
                    L[i] = nx; why[i] = (fl[i] != 0) ? "R11" : "R3";
                end else begin
                    L[i] = RS[i]; why[i] = "R4";
                end
                fl[i] = (msk[i] != 16'd0) ? 1 : 0;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b0;
        for (int i = 0; i < NI; i++) begin
            nxt[i] = 3'd0; msk[i] = 16'd0; L[i] = PW[i]; fl[i] = 0; why[i] = "R2";
        end
        #1;
        check_all();                       // R2 power-on contents
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            L[i] = RS[i]; why[i] = "R1";
        end
        repeat (12) step(1'b0, -1, 1'b0);  // R3 clean counting
        for (int b = 0; b < 12; b++) begin // R5 single flip on every bit
            step(1'b0, b, 1'b0);
            step(1'b0, -1, 1'b0);
            step(1'b0, -1, 1'b0);
        end
        step(1'b0, -1, 1'b1);              // R4 out-of-range next index
        step(1'b0, -1, 1'b0);
        step(1'b0, -1, 1'b0);
        step(1'b1, 3, 1'b0);               // R1 reset overrides mask
        step(1'b0, -1, 1'b0);
        step(1'b0, -1, 1'b0);
        step(1'b0, 1, 1'b0);               // flips on consecutive cycles
        step(1'b0, 2, 1'b0);
        step(1'b0, 0, 1'b0);
        step(1'b0, -1, 1'b0);
        step(1'b0, -1, 1'b0);
        check_all();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL R3 watchdog: run still active, expected completion");
        report();
    end

endmodule